// File: doc/BRIEF.md
# Protected Code Readback Unit

This block answers verify reads of a small on-chip code store, with two protections applied to what comes out. Each byte read from the store is combined with a 64-entry secret byte table. The table entry is picked by the low six address bits, and the byte shown is the bitwise complement of the code byte XOR that entry. Every table entry powers up as 0xFF, so an unprogrammed table passes code through unchanged.

Three sticky lock bits sit on top of the table. The first lock freezes both the code store and the table against further writes. The second lock makes every verify read return 0xFF. The third lock is only reported to the rest of the chip, as a flag that turns off fetching from external memory.

A lock bit can be set only when the lock below it is already set. A request that breaks this order is dropped, and an error flag pulses for one cycle. Lock bits clear only on the power-on reset. The code store has a write port so that a test environment can load it before any lock is set.

Top module: `codeguard_verify`

## Requirements
- R1: While rst_n is low and after it rises, lock_state is 000, lock_err is 0, ext_exec_off is 0, rd_valid is 0, and all 64 table entries are 0xFF. The code store is not cleared by reset.
- R2: A read sampled with rd_req high at a clock edge drives rd_valid high for exactly the following cycle. In that cycle rd_data is ~(code[rd_addr] ^ table[rd_addr mod 64]).
- R3: With every table entry at its reset value 0xFF, rd_data equals the stored code byte at every address.
- R4: Addresses that agree in their low six bits use the same table entry, and key_idx selects the entry that key_we writes.
- R5: lock_sel encodes a lock request as 1 for lock 1, 2 for lock 2 and 3 for lock 3. A lock_req with lock_sel 0 changes nothing and raises no error. An accepted request shows in lock_state (bit 0 = lock 1, bit 1 = lock 2, bit 2 = lock 3) one cycle later.
- R6: A request for lock 2 while lock 1 is clear, or for lock 3 while lock 2 is clear, leaves lock_state unchanged. It sets lock_err for exactly one cycle.
- R7: Lock bits never clear while rst_n stays high, and repeating a request for a lock that is already set causes no error. Only rst_n low clears them.
- R8: While lock 1 is set, prog_we and key_we writes have no effect on later reads.
- R9: While lock 2 is set, every read returns 0xFF whatever the address and table.
- R10: ext_exec_off follows lock 3 (lock_state bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| prog_we | input | 1 | Code store write strobe |
| prog_addr | input | ADDR_W | Code store write address |
| prog_data | input | 8 | Code store write data |
| key_we | input | 1 | Table write strobe |
| key_idx | input | log2(TBL_DEPTH) | Table entry to write |
| key_data | input | 8 | Table write data |
| lock_req | input | 1 | Lock set request |
| lock_sel | input | 2 | Lock level requested (0 none, 1..3) |
| rd_req | input | 1 | Verify read strobe |
| rd_addr | input | ADDR_W | Verify read address |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Displayed byte |
| lock_state | output | 3 | Current lock bits |
| lock_err | output | 1 | One-cycle pulse on a rejected lock request |
| ext_exec_off | output | 1 | External execution disabled (lock 3) |

## Verification
Reads are first made at both ends of the address range with the table at its reset value, which shows whether the stored bytes pass through unchanged. Keys of 0x00, 0xA5 and 0x3C are then loaded and read at addresses 64 apart, which separates correct modulo-64 indexing, the complement, and the XOR from each other. Lock requests are sent out of order, with level 0, and repeated, which tells the error path apart from the quiet paths. Write attempts made after lock 1 and reads made after lock 2 show whether the freeze and the all-ones forcing work, and a final reset shows that locks and table return to their reset values while the code stays.

// File: rtl/cgv_pkg.sv
package cgv_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        LREQ_NONE = 2'd0,
        LREQ_L1   = 2'd1,
        LREQ_L2   = 2'd2,
        LREQ_L3   = 2'd3
    } lock_req_e;

    typedef struct packed {
        logic [2:0] bits;
        logic       err;
    } lock_state_t;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } rd_stage_t;

    function automatic byte_t unscramble(byte_t code, byte_t key);
        return ~(code ^ key);
    endfunction
endpackage

// File: rtl/cgv_lock_ctrl.sv
module cgv_lock_ctrl
    import cgv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic [1:0] sel_i,
    output logic [2:0] bits_o,
    output logic       err_o
);
    timeunit 1ns;
    timeprecision 1ps;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (req_i) begin
            case (lock_req_e'(sel_i))
                LREQ_L1: st_d.bits[0] = 1'b1;
                LREQ_L2: begin
                    if (st_q.bits[0]) st_d.bits[1] = 1'b1;
                    else              st_d.err     = 1'b1;
                end
                LREQ_L3: begin
                    if (st_q.bits[1]) st_d.bits[2] = 1'b1;
                    else              st_d.err     = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_o = st_q.bits;
    assign err_o  = st_q.err;

    // R7: once set, a lock bit stays set until reset
    p_bits_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        &(st_q.bits | ~$past(st_q.bits)));
    // R6: higher locks imply the lower ones
    p_chain_l2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bits[1] |-> st_q.bits[0]);
    p_chain_l3_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bits[2] |-> st_q.bits[1]);
    // R6: an error only follows a request for lock 2 or 3
    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> ($past(req_i) && $past(sel_i) >= 2'd2));
    // R6: a rejected request leaves the bits untouched
    p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> $stable(st_q.bits));
endmodule

// File: rtl/cgv_mask_table.sv
module cgv_mask_table
    import cgv_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  byte_t            wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output byte_t            rdata_o
);
    timeunit 1ns;
    timeprecision 1ps;

    byte_t tbl_d [DEPTH];
    byte_t tbl_q [DEPTH];

    always_comb begin
        tbl_d = tbl_q;
        if (we_i) tbl_d[widx_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= 8'hFF;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rdata_o = tbl_q[ridx_i];

    // R4: an accepted write lands in the indexed entry
    p_tbl_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> tbl_q[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/cgv_code_store.sv
module cgv_code_store
    import cgv_pkg::*;
#(
    parameter  int ADDR_W = 8,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  byte_t             wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output byte_t             rdata_o
);
    timeunit 1ns;
    timeprecision 1ps;

    byte_t mem_d [DEPTH];
    byte_t mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata_o = mem_q[raddr_i];

    // R8: a gated write still reaches the array when allowed
    p_store_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/codeguard_verify.sv
module codeguard_verify
    import cgv_pkg::*;
#(
    parameter  int ADDR_W    = 8,
    parameter  int TBL_DEPTH = 64,
    localparam int TBL_IW    = $clog2(TBL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              key_we,
    input  logic [TBL_IW-1:0] key_idx,
    input  logic [7:0]        key_data,
    input  logic              lock_req,
    input  logic [1:0]        lock_sel,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic [2:0]        lock_state,
    output logic              lock_err,
    output logic              ext_exec_off
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [2:0]        lk_bits;
    logic              lk_err;
    logic              wr_open;
    logic [TBL_IW-1:0] tbl_ridx;
    byte_t             code_byte;
    byte_t             key_byte;
    rd_stage_t         rd_d, rd_q;

    assign wr_open = ~lk_bits[0];

    cgv_lock_ctrl u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (lock_req),
        .sel_i  (lock_sel),
        .bits_o (lk_bits),
        .err_o  (lk_err)
    );

    cgv_code_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (prog_we & wr_open),
        .waddr_i (prog_addr),
        .wdata_i (prog_data),
        .raddr_i (rd_addr),
        .rdata_o (code_byte)
    );

    generate
        if (ADDR_W >= TBL_IW) begin : g_idx_slice
            assign tbl_ridx = rd_addr[TBL_IW-1:0];
        end else begin : g_idx_pad
            assign tbl_ridx = {{(TBL_IW-ADDR_W){1'b0}}, rd_addr};
        end
    endgenerate

    cgv_mask_table #(.DEPTH(TBL_DEPTH)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (key_we & wr_open),
        .widx_i  (key_idx),
        .wdata_i (key_data),
        .ridx_i  (tbl_ridx),
        .rdata_o (key_byte)
    );

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_req;
        if (rd_req) begin
            rd_d.data = lk_bits[1] ? 8'hFF : unscramble(code_byte, key_byte);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid     = rd_q.valid;
    assign rd_data      = rd_q.data;
    assign lock_state   = lk_bits;
    assign lock_err     = lk_err;
    assign ext_exec_off = lk_bits[2];

    // R2: valid follows the read strobe by one cycle
    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    // R9: reads under lock 2 show all ones
    p_lock2_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && lock_state[1]) |=> rd_data == 8'hFF);
endmodule

// File: tb/tb_codeguard_verify.sv
module tb_codeguard_verify;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_we = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [7:0]    prog_data = '0;
    logic          key_we = 1'b0;
    logic [5:0]    key_idx = '0;
    logic [7:0]    key_data = '0;
    logic          lock_req = 1'b0;
    logic [1:0]    lock_sel = '0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic [2:0]    lock_state;
    logic          lock_err;
    logic          ext_exec_off;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [7:0] code_m [256];
    logic [7:0] key_m  [64];
    logic [2:0] lk_m;

    always #10 clk = ~clk;

    codeguard_verify #(.ADDR_W(AW), .TBL_DEPTH(64)) dut (
        .clk(clk), .rst_n(rst_n),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .key_we(key_we), .key_idx(key_idx), .key_data(key_data),
        .lock_req(lock_req), .lock_sel(lock_sel),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .lock_state(lock_state), .lock_err(lock_err),
        .ext_exec_off(ext_exec_off)
    );

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_rd(int a);
        if (lk_m[1]) return 8'hFF;
        return ~(code_m[a] ^ key_m[a % 64]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "lock_state in reset", {5'd0, lock_state}, 8'h00);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) key_m[i] = 8'hFF;
        lk_m = 3'b000;
    endtask

    task automatic prog(int a, logic [7:0] d);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = AW'(a); prog_data = d;
        @(negedge clk);
        prog_we = 1'b0;
        if (!lk_m[0]) code_m[a] = d;
    endtask

    task automatic key(int i, logic [7:0] d);
        @(negedge clk);
        key_we = 1'b1; key_idx = 6'(i); key_data = d;
        @(negedge clk);
        key_we = 1'b0;
        if (!lk_m[0]) key_m[i] = d;
    endtask

    task automatic rd(string req, int a);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = AW'(a);
        @(posedge clk); #1;
        chk(req, "rd_valid after read", {7'd0, rd_valid}, 8'h01);
        chk(req, $sformatf("rd_data @%0d", a), rd_data, expect_rd(a));
        @(negedge clk);
        rd_req = 1'b0;
        @(posedge clk); #1;
        chk("R2", "rd_valid drops", {7'd0, rd_valid}, 8'h00);
    endtask

    task automatic lock(string req, logic [1:0] s, bit exp_err);
        @(negedge clk);
        lock_req = 1'b1; lock_sel = s;
        @(posedge clk); #1;
        if (!exp_err && s != 2'd0) lk_m[s-1] = 1'b1;
        chk(req, "lock_err pulse", {7'd0, lock_err}, {7'd0, exp_err});
        chk(req, "lock_state", {5'd0, lock_state}, {5'd0, lk_m});
        @(negedge clk);
        lock_req = 1'b0;
        @(posedge clk); #1;
        chk(req, "lock_err clears", {7'd0, lock_err}, 8'h00);
    endtask

    task automatic t_reset_state();
        chk("R1", "rd_valid", {7'd0, rd_valid}, 8'h00);
        chk("R1", "lock_state", {5'd0, lock_state}, 8'h00);
        chk("R1", "lock_err", {7'd0, lock_err}, 8'h00);
        chk("R1", "ext_exec_off", {7'd0, ext_exec_off}, 8'h00);
    endtask

    task automatic t_plain();
        for (int i = 0; i < 256; i++) prog(i, 8'((i * 37 + 5) & 255));
        foreach (code_m[i]) if (i == 0 || i == 63 || i == 64 || i == 200 || i == 255)
            rd("R3", i);
    endtask

    task automatic t_keyed();
        key(5, 8'h3C);
        key(63, 8'h00);
        key(0, 8'hA5);
        rd("R2", 5);
        rd("R4", 69);
        rd("R4", 133);
        rd("R4", 197);
        rd("R2", 63);
        rd("R4", 127);
        rd("R4", 255);
        rd("R2", 0);
        rd("R4", 128);
        rd("R4", 1);
    endtask

    task automatic t_lock_order();
        lock("R6", 2'd2, 1'b1);
        lock("R6", 2'd3, 1'b1);
        lock("R5", 2'd0, 1'b0);
        lock("R5", 2'd1, 1'b0);
        lock("R6", 2'd3, 1'b1);
    endtask

    task automatic t_freeze();
        key(5, 8'h11);
        prog(5, 8'h00);
        prog(64, 8'h77);
        key(0, 8'h00);
        rd("R8", 5);
        rd("R8", 64);
        rd("R8", 0);
    endtask

    task automatic t_lock2();
        lock("R5", 2'd2, 1'b0);
        rd("R9", 0);
        rd("R9", 5);
        rd("R9", 100);
        rd("R9", 255);
    endtask

    task automatic t_lock3();
        chk("R10", "ext_exec_off before lock 3", {7'd0, ext_exec_off}, 8'h00);
        lock("R5", 2'd3, 1'b0);
        chk("R10", "ext_exec_off", {7'd0, ext_exec_off}, 8'h01);
        lock("R7", 2'd1, 1'b0);
        lock("R7", 2'd2, 1'b0);
        repeat (4) @(posedge clk);
        #1;
        chk("R7", "locks stay set", {5'd0, lock_state}, 8'h07);
    endtask

    task automatic t_power_cycle();
        do_reset();
        @(posedge clk); #1;
        chk("R7", "locks cleared by reset", {5'd0, lock_state}, 8'h00);
        chk("R1", "ext_exec_off cleared", {7'd0, ext_exec_off}, 8'h00);
        rd("R1", 5);
        rd("R1", 0);
        rd("R1", 63);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) code_m[i] = 8'h00;
        for (int i = 0; i < 64; i++) key_m[i] = 8'hFF;
        lk_m = 3'b000;
        repeat (2) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset_state();
        t_plain();
        t_keyed();
        t_lock_order();
        t_freeze();
        t_lock2();
        t_lock3();
        t_power_cycle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule